// File: doc/BRIEF.md
# Multiple Stuck-at Fault Injection Wrapper

This block sits on a bundle of signal lines and lets a single control point emulate a simultaneous multiple stuck-at fault across any chosen subset of them. A two-input gate is inserted on each line that can be targeted. An OR gate pulls the line high for a stuck-at-1 fault, and an AND gate pulls it low for a stuck-at-0 fault. Both gate types take their second input from one shared detector. That detector is an AND over all targeted lines. It reads stuck-at-1 lines directly and stuck-at-0 lines inverted. Its output feeds the OR gates directly and the AND gates through one inverter.

The activation input models a stuck-at-1 on the detector output. When it is low, the wrapper is fully transparent. When it is high, every targeted line takes its stuck value in the same evaluation. Each line's fault polarity and whether it is targeted are chosen by two per-line masks. The wrapper holds no state: its outputs follow its inputs combinationally.

Top module: `msa_inject`

## Requirements
- R1: With `force_on` low, `line_out` equals `good_in` on every line for any values of `stuck_hi` and `target`.
- R2: With `force_on` high, every line whose `target` bit is 1 and whose `stuck_hi` bit is 1 reads 1 on `line_out`.
- R3: With `force_on` high, every line whose `target` bit is 1 and whose `stuck_hi` bit is 0 reads 0 on `line_out`.
- R4: A line whose `target` bit is 0 always has `line_out` equal to `good_in`, whether `force_on` is high or low and whatever its `stuck_hi` bit is.
- R5: When every targeted line already carries its stuck value (`good_in` equals `stuck_hi` on all lines with `target` set), the internal detector fires on its own, yet `line_out` still equals `good_in`.
- R6: One activation can apply stuck-at-1 and stuck-at-0 faults at once on different lines of the same bundle. The polarity is taken per line from `stuck_hi` (bit value 1 means stuck-at-1, bit value 0 means stuck-at-0).
- R7: The wrapper has no clock and no state. A change on any input appears on `line_out` in the same evaluation, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| good_in | input | LINES | Fault-free values of the wrapped lines |
| stuck_hi | input | LINES | Per-line stuck polarity: 1 means stuck-at-1, 0 means stuck-at-0 |
| target | input | LINES | Per-line select: 1 means the line takes part in the fault |
| force_on | input | 1 | Activates the modelled multiple fault |
| line_out | output | LINES | Line values after the inserted gates |

## Verification
Every result of this block is due in the same evaluation as the stimulus that causes it, because no register lies between any input and `line_out`. The bench therefore changes inputs just after a rising edge and compares `line_out` at the following falling edge, half a period later. The reference model has already been computed from the same inputs at that point, so no expected value is delayed or queued. Directed patterns cover full, empty and mixed-polarity target masks, as well as good values that already match the stuck pattern. Random patterns sweep both activation states.

// File: rtl/msa_inject.sv
module msa_inject #(
  parameter int unsigned LINES = 8
) (
  input  logic [LINES-1:0] good_in,
  input  logic [LINES-1:0] stuck_hi,
  input  logic [LINES-1:0] target,
  input  logic             force_on,
  output logic [LINES-1:0] line_out
);

  logic [LINES-1:0] det_term;
  logic             det_natural;
  logic             det_out;
  logic             det_n;

  // Detector inputs come from the fault-free side of each in-line gate,
  // so the loop through the detector stays structural and never closes.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic or_gate;
    logic and_gate;

    assign det_term[i] = ~target[i] | ~(good_in[i] ^ stuck_hi[i]);
    assign or_gate     = good_in[i] | det_out;
    assign and_gate    = good_in[i] & det_n;
    assign line_out[i] = !target[i] ? good_in[i]
                       : (stuck_hi[i] ? or_gate : and_gate);
  end

  assign det_natural = &det_term;
  assign det_out     = det_natural | force_on;
  assign det_n       = ~det_out;

  always_comb begin
    if (!force_on) begin
      AST_IDLE_TRANSPARENT: assert (line_out == good_in) else $error("idle wrapper altered a line"); // R1
    end
    if (force_on) begin
      AST_FORCE_ONES: assert ((line_out & target & stuck_hi) == (target & stuck_hi)) else $error("stuck-at-1 line not high"); // R2
      AST_FORCE_ZEROS: assert ((line_out & target & ~stuck_hi) == '0) else $error("stuck-at-0 line not low"); // R3
    end
    AST_UNTARGETED_PASS: assert (((line_out ^ good_in) & ~target) == '0) else $error("untargeted line altered"); // R4
    if (((good_in ^ stuck_hi) & target) == '0) begin
      AST_NATURAL_FIRE_HIDDEN: assert (line_out == good_in) else $error("natural detector firing visible"); // R5
    end
  end

endmodule

// File: tb/sim_msa_inject.sv
`timescale 1ns/1ps
module sim_msa_inject;
  localparam int W = 8;
  localparam int RAND_CYCLES = 3000;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] g = '0;
  logic [W-1:0] s = '0;
  logic [W-1:0] t = '0;
  logic f = 1'b0;
  logic [W-1:0] out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  msa_inject #(.LINES(W)) u0 (
    .good_in(g), .stuck_hi(s), .target(t), .force_on(f), .line_out(out)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] gv, input logic [W-1:0] sv,
                                          input logic [W-1:0] tv, input logic fv);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) begin
      if (fv && tv[k]) r[k] = sv[k];
      else r[k] = gv[k];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (g=%h s=%h t=%h f=%b)", req, act, exp, g, s, t, f);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] exp;
    exp = model(g, s, t, f);
    check(out == exp, "R6 full vector", out, exp);
    if (!f) check(out == g, "R1 idle transparent", out, g);
    else begin
      check((out & t & s) == (t & s), "R2 stuck-at-1 lines high", out & t & s, t & s);
      check((out & t & ~s) == '0, "R3 stuck-at-0 lines low", out & t & ~s, '0);
    end
    check(((out ^ g) & ~t) == '0, "R4 untargeted pass", out & ~t, g & ~t);
    if (((g ^ s) & t) == '0) check(out == g, "R5 natural fire hidden", out, g);
  endtask

  task automatic apply(input logic [W-1:0] gv, input logic [W-1:0] sv,
                       input logic [W-1:0] tv, input logic fv);
    @(posedge clk);
    #1;
    g = gv; s = sv; t = tv; f = fv;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out == '0, "R1 reset state", out, '0);
    rst = 1'b0;

    apply(8'h3C, 8'hA5, 8'hFF, 1'b1);
    check(out == 8'hA5, "R6 mixed polarity all targeted", out, 8'hA5);
    apply(8'h3C, 8'hA5, 8'hFF, 1'b0);
    check(out == 8'h3C, "R1 same masks idle", out, 8'h3C);
    apply(8'h5A, 8'hFF, 8'h00, 1'b1);
    check(out == 8'h5A, "R4 empty target mask", out, 8'h5A);
    apply(8'h00, 8'hFF, 8'h0F, 1'b1);
    check(out == 8'h0F, "R2 low nibble stuck high", out, 8'h0F);
    apply(8'hFF, 8'h00, 8'hF0, 1'b1);
    check(out == 8'h0F, "R3 high nibble stuck low", out, 8'h0F);
    apply(8'h96, 8'h96, 8'hFF, 1'b0);
    check(out == 8'h96, "R5 matching pattern idle", out, 8'h96);
    apply(8'h96, 8'h96, 8'h3C, 1'b1);
    check(out == 8'h96, "R5 matching pattern forced", out, 8'h96);

    @(posedge clk);
    #1;
    g = 8'h00; s = 8'hFF; t = 8'hFF; f = 1'b0;
    #1;
    check(out == 8'h00, "R7 idle same evaluation", out, 8'h00);
    f = 1'b1;
    #1;
    check(out == 8'hFF, "R7 activation same evaluation", out, 8'hFF);
    g = 8'hFF; f = 1'b0;
    #1;
    check(out == 8'hFF, "R7 release same evaluation", out, 8'hFF);

    for (int n = 0; n < RAND_CYCLES; n++) begin
      apply(W'($urandom), W'($urandom), W'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule